// File: doc/BRIEF.md
# Memory-Mapped Serial and Pin Peripheral

This block hangs off a small processor's 32-bit system bus and gives software two services through a window of word registers at a fixed high address. The first service is a byte channel. Bytes that software writes are held in a transmit queue until an external serializer takes them. Bytes that the serializer delivers are held in a receive queue until software reads them. The second service is a bank of general-purpose pins. Each pin has its own output-enable bit and its own output level, and the pin levels read back through a two-stage synchronizer.

The block has no interrupt. Software polls two flag registers. One flag is set while the transmit queue cannot take another byte. The other is set while nothing has been received. A read of the receive-data register removes the byte it returns. The bus is single-cycle: read data is valid combinationally in the cycle of the request, and every state change happens at the following rising clock edge.

Top module: `mmio_serial_gpio`

## Requirements
- R1: A bus write to BASE+0x00 appends wdata[7:0] to a 16-entry transmit queue when the queue is not full. tx_valid is high while the queue holds a byte, and tx_data shows the oldest byte. A byte leaves the queue on a clock edge where tx_valid and tx_ready are both high.
- R2: A read of BASE+0x04 returns 1 while the transmit queue holds 16 bytes and returns 0 otherwise.
- R3: A write to BASE+0x00 while the transmit queue is full is discarded, and the queued bytes and their order are unchanged. A write and a drain in the same cycle on a full queue still drops the write, because acceptance depends on the fill level before the edge.
- R4: A read of BASE+0x08 returns the oldest received byte in bits [7:0], with zeros above, and removes that byte at the end of the cycle. When the receive queue is empty, the read returns 0 and changes nothing.
- R5: A read of BASE+0x0C returns 1 while the receive queue is empty and returns 0 otherwise.
- R6: rx_ready is high whenever the 16-entry receive queue holds fewer than 16 bytes. rx_data is stored on a clock edge where rx_valid and rx_ready are both high.
- R7: A read of BASE+0x10 returns gpio_in as it was sampled two rising edges earlier, in the low N_PINS bits. A write there loads wdata[N_PINS-1:0] into gpio_out.
- R8: A write to BASE+0x14 loads the direction bits, and gpio_oe equals them (1 = drive the pin). A read of BASE+0x14 returns them.
- R9: The following all read as 0: offsets 0x00, 0x18 and 0x1C; any address outside the 32-byte window; any address with a nonzero addr[1:0]; and any cycle that is not a read. Writes to any of these locations have no effect.
- R10: An active-low reset empties both queues and clears gpio_out, gpio_oe and the synchronizer. Release is synchronized, so the block takes bus operations from the third rising edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Serializer offers a byte |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | 8 | Offered receive byte |
| gpio_in | input | N_PINS | Pin levels from the pads |
| gpio_out | output | N_PINS | Pin output levels |
| gpio_oe | output | N_PINS | Pin output enables |

## Verification
The queues are tested first with directed bursts. The transmit queue is overfilled with the drain stalled, which separates accepted writes from dropped ones. The receive queue is flooded and then read past empty, which separates a real pop from a harmless empty read. Both queues are then driven full with a push and a pop in the same cycle, which shows whether acceptance uses the fill level before or after the edge. The pins get walking patterns with the input changing one edge before each read, so a synchronizer one stage too short or too long shows up. A long random mix of window, off-window and misaligned addresses with random handshakes, followed by a reset in mid-traffic, is compared against the reference model on every cycle.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  localparam int unsigned REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    SEL_TX_BYTE  = 3'd0,
    SEL_TX_FULL  = 3'd1,
    SEL_RX_BYTE  = 3'd2,
    SEL_RX_EMPTY = 3'd3,
    SEL_PIN_VAL  = 3'd4,
    SEL_PIN_DIR  = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic                 rd_en;
    logic                 tx_push;
    logic                 rx_pop;
    logic                 val_wr;
    logic                 dir_wr;
    logic [REG_IDX_W-1:0] sel;
  } bus_cmd_t;
endpackage

// File: rtl/sgp_rst_sync.sv
module sgp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/sgp_byte_fifo.sv
module sgp_byte_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [AW:0]      wptr_q, wptr_d, rptr_q, rptr_d;
  logic [WIDTH-1:0] slot_q [DEPTH];
  logic             do_push, do_pop;

  assign empty_o = (wptr_q == rptr_q);
  assign full_o  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = slot_q[rptr_q[AW-1:0]];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (do_push) wptr_d = wptr_q + {{AW{1'b0}}, 1'b1};
    if (do_pop)  rptr_d = rptr_q + {{AW{1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  // storage has no reset; each slot is enabled by its own write strobe
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = do_push && (wptr_q[AW-1:0] == AW'(i));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[i] <= push_data_i;
    end
  end
endmodule

// File: rtl/sgp_pin_sync.sv
module sgp_pin_sync #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] pin_o
);
  logic [N-1:0] meta_q, stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= pin_i;
      stable_q <= meta_q;
    end
  end

  assign pin_o = stable_q;
endmodule

// File: rtl/sgp_bus_decode.sv
module sgp_bus_decode
  import sgp_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hE000_0000
) (
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic        tx_full,
  input  logic        rx_empty,
  output bus_cmd_t    cmd
);
  localparam int unsigned WIN_LSB = REG_IDX_W + 2;

  logic hit, wr, rd;

  assign hit = (bus_addr[31:WIN_LSB] == BASE_ADDR[31:WIN_LSB]) && (bus_addr[1:0] == 2'b00);
  assign wr  = bus_req && bus_we && hit;
  assign rd  = bus_req && !bus_we && hit;

  always_comb begin
    cmd         = '0;
    cmd.sel     = bus_addr[WIN_LSB-1:2];
    cmd.rd_en   = rd;
    cmd.tx_push = wr && (cmd.sel == SEL_TX_BYTE) && !tx_full;
    cmd.val_wr  = wr && (cmd.sel == SEL_PIN_VAL);
    cmd.dir_wr  = wr && (cmd.sel == SEL_PIN_DIR);
    cmd.rx_pop  = rd && (cmd.sel == SEL_RX_BYTE) && !rx_empty;
  end
endmodule

// File: rtl/mmio_serial_gpio.sv
module mmio_serial_gpio
  import sgp_pkg::*;
#(
  parameter int unsigned N_PINS     = 16,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter logic [31:0] BASE_ADDR  = 32'hE000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic [N_PINS-1:0] gpio_in,
  output logic [N_PINS-1:0] gpio_out,
  output logic [N_PINS-1:0] gpio_oe
);
  logic              rst_int_n;
  bus_cmd_t          cmd;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0]        rx_head;
  logic [N_PINS-1:0] pin_seen;
  logic [N_PINS-1:0] out_q, out_d, dir_q, dir_d;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  sgp_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  sgp_bus_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .tx_full(tx_full), .rx_empty(rx_empty), .cmd(cmd)
  );

  sgp_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_int_n),
    .push_i(cmd.tx_push), .push_data_i(bus_wdata[7:0]),
    .pop_i(tx_ready), .head_o(tx_data),
    .empty_o(tx_empty), .full_o(tx_full)
  );

  sgp_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_int_n),
    .push_i(rx_valid), .push_data_i(rx_data),
    .pop_i(cmd.rx_pop), .head_o(rx_head),
    .empty_o(rx_empty), .full_o(rx_full)
  );

  sgp_pin_sync #(.N(N_PINS)) u_pins (
    .clk(clk), .rst_n(rst_int_n), .pin_i(gpio_in), .pin_o(pin_seen)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  always_comb begin
    out_d = out_q;
    dir_d = dir_q;
    if (cmd.val_wr) out_d = bus_wdata[N_PINS-1:0];
    if (cmd.dir_wr) dir_d = bus_wdata[N_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      out_q <= out_d;
      dir_q <= dir_d;
    end
  end

  assign gpio_out = out_q;
  assign gpio_oe  = dir_q;

  always_comb begin
    bus_rdata = '0;
    if (cmd.rd_en) begin
      case (cmd.sel)
        SEL_TX_FULL:  bus_rdata[0] = tx_full;
        SEL_RX_BYTE:  bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
        SEL_RX_EMPTY: bus_rdata[0] = rx_empty;
        SEL_PIN_VAL:  bus_rdata[N_PINS-1:0] = pin_seen;
        SEL_PIN_DIR:  bus_rdata[N_PINS-1:0] = dir_q;
        default:      bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mmio_serial_gpio_chk.sv
module mmio_serial_gpio_chk #(
  parameter int unsigned N_PINS    = 16,
  parameter logic [31:0] BASE_ADDR = 32'hE000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [31:0]       bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              rx_ready,
  input logic [N_PINS-1:0] gpio_out,
  input logic [N_PINS-1:0] gpio_oe
);
  logic rd_byte, rd_flag, wr_val, wr_dir;

  assign rd_byte = bus_req && !bus_we && (bus_addr == BASE_ADDR + 32'h08);
  assign rd_flag = bus_req && !bus_we &&
                   ((bus_addr == BASE_ADDR + 32'h04) || (bus_addr == BASE_ADDR + 32'h0C));
  assign wr_val  = bus_req && bus_we && (bus_addr == BASE_ADDR + 32'h10);
  assign wr_dir  = bus_req && bus_we && (bus_addr == BASE_ADDR + 32'h14);

  // R1: an unclaimed byte stays on offer unchanged
  a_r1_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R6: a full receive queue frees space only through a byte read
  a_r6_rx_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && !rd_byte) |=> !rx_ready);

  // R7: output levels move only on a value write
  a_r7_out_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_val |=> $stable(gpio_out));

  // R8: enables move only on a direction write
  a_r8_oe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(gpio_oe));

  // R9: no read, no data
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (bus_rdata == 32'h0));

  // R2, R5: flag registers are single-bit
  a_r5_flag_width: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flag |-> (bus_rdata[31:1] == 31'h0));
endmodule

bind mmio_serial_gpio mmio_serial_gpio_chk #(.N_PINS(N_PINS), .BASE_ADDR(BASE_ADDR)) chk_i (.*);

// File: tb/mmio_serial_gpio_tb.sv
module mmio_serial_gpio_tb_top;
  localparam int N = 16;
  localparam int DEPTH = 16;
  localparam logic [31:0] BASE = 32'hE000_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_req = 0, bus_we = 0, tx_ready = 0, rx_valid = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic [7:0] rx_data = 0;
  logic [N-1:0] gpio_in = 0;
  wire [31:0] bus_rdata;
  wire tx_valid, rx_ready;
  wire [7:0] tx_data;
  wire [N-1:0] gpio_out, gpio_oe;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mmio_serial_gpio dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  // behavioural reference model
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [N-1:0] m_out = 0, m_dir = 0, m_s1 = 0, m_s2 = 0;
  bit m_r1 = 0, m_r2 = 0;

  function automatic bit in_win(logic [31:0] a);
    return (a >= BASE) && (a < BASE + 32'h20) && (a[1:0] == 2'b00);
  endfunction

  task automatic model_clear();
    txq.delete(); rxq.delete();
    m_out = 0; m_dir = 0; m_s1 = 0; m_s2 = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; model_clear();
    end else begin
      bit was_live;
      int tx_n, rx_n;
      was_live = m_r2;
      m_r2 = m_r1; m_r1 = 1;
      if (!was_live) model_clear();
      else begin
        tx_n = txq.size(); rx_n = rxq.size();
        if (tx_ready && tx_n > 0) void'(txq.pop_front());
        if (bus_req && bus_we && bus_addr == BASE && tx_n < DEPTH) txq.push_back(bus_wdata[7:0]);
        if (bus_req && !bus_we && bus_addr == BASE + 8 && rx_n > 0) void'(rxq.pop_front());
        if (rx_valid && rx_n < DEPTH) rxq.push_back(rx_data);
        if (bus_req && bus_we && bus_addr == BASE + 32'h10) m_out = bus_wdata[N-1:0];
        if (bus_req && bus_we && bus_addr == BASE + 32'h14) m_dir = bus_wdata[N-1:0];
        m_s2 = m_s1; m_s1 = gpio_in;
      end
    end
  end

  function automatic logic [31:0] exp_rdata();
    logic [31:0] r = 0;
    if (!bus_req || bus_we || !in_win(bus_addr)) return 0;
    case (bus_addr[4:2])
      3'd1: r = {31'h0, txq.size() == DEPTH};
      3'd2: r = (rxq.size() > 0) ? {24'h0, rxq[0]} : 32'h0;
      3'd3: r = {31'h0, rxq.size() == 0};
      3'd4: r[N-1:0] = m_s2;
      3'd5: r[N-1:0] = m_dir;
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string rd_tag();
    if (!m_r2) return "R10";
    if (!in_win(bus_addr)) return "R9";
    case (bus_addr[4:2])
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check(rd_tag(), "bus_rdata", bus_rdata, exp_rdata());
    check(m_r2 ? "R1" : "R10", "tx_valid", {31'h0, tx_valid}, {31'h0, txq.size() > 0});
    if (txq.size() > 0) check("R1 R3", "tx_data", {24'h0, tx_data}, {24'h0, txq[0]});
    check(m_r2 ? "R6" : "R10", "rx_ready", {31'h0, rx_ready}, {31'h0, rxq.size() < DEPTH});
    check(m_r2 ? "R7" : "R10", "gpio_out", {16'h0, gpio_out}, {16'h0, m_out});
    check(m_r2 ? "R8" : "R10", "gpio_oe", {16'h0, gpio_oe}, {16'h0, m_dir});
  endtask

  task automatic bus(bit we, logic [31:0] a, logic [31:0] d);
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    cyc();
    bus_req = 0; bus_we = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    rst_n = 1;
    #1 rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(3);
    // R2 R3: overfill with drain stalled
    for (int i = 0; i < 20; i++) bus(1, BASE, 32'hA0 + i);
    bus(0, BASE + 4, 0);
    bus(0, BASE, 0);
    // R3: full queue, drain and write same cycle
    tx_ready = 1;
    bus(1, BASE, 32'h55);
    tx_ready = 0;
    bus(0, BASE + 4, 0);
    tx_ready = 1; idle(18); tx_ready = 0;
    bus(0, BASE + 4, 0);
    // R6 R4 R5: flood receive, then read past empty
    rx_valid = 1;
    for (int i = 0; i < 19; i++) begin rx_data = 8'h30 + 8'(i); cyc(); end
    rx_valid = 0;
    bus(0, BASE + 12, 0);
    for (int i = 0; i < 18; i++) bus(0, BASE + 8, 0);
    bus(0, BASE + 12, 0);
    // R4 R6: push and pop same cycle on a full queue
    rx_valid = 1;
    for (int i = 0; i < 16; i++) begin rx_data = 8'h70 + 8'(i); cyc(); end
    rx_data = 8'hEE; bus(0, BASE + 8, 0);
    rx_valid = 0;
    for (int i = 0; i < 17; i++) bus(0, BASE + 8, 0);
    // R7 R8: pins
    bus(1, BASE + 32'h14, 32'h0000_F0F0);
    bus(1, BASE + 32'h10, 32'hFFFF_A5C3);
    for (int i = 0; i < N; i++) begin
      gpio_in = N'(1) << i;
      bus(0, BASE + 32'h10, 0);
      bus(0, BASE + 32'h10, 0);
    end
    bus(0, BASE + 32'h14, 0);
    // R9: holes, misaligned, outside window
    bus(1, BASE + 32'h18, 32'hFFFF_FFFF);
    bus(1, BASE + 32'h11, 32'h1234);
    bus(1, 32'h6000_0014, 32'h1);
    bus(1, BASE + 32'h34, 32'h1);
    bus(0, BASE + 32'h18, 0);
    bus(0, BASE + 32'h1C, 0);
    bus(0, BASE + 32'h16, 0);
    bus(0, BASE + 32'h20, 0);
    bus(0, 32'h6000_0010, 0);
    bus(0, BASE, 0);
    bus(0, BASE + 32'h14, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bus_req = 1'($urandom); bus_we = 1'($urandom);
      case ($urandom % 10)
        0: bus_addr = BASE + 32'h20;
        1: bus_addr = 32'h6000_0008;
        2: bus_addr = BASE + 32'h9;
        default: bus_addr = BASE + (($urandom % 8) << 2);
      endcase
      bus_wdata = $urandom;
      tx_ready = ($urandom % 4) == 0;
      rx_valid = 1'($urandom);
      rx_data = 8'($urandom);
      if (($urandom % 8) == 0) gpio_in = N'($urandom);
      if (i == 2500) rst_n = 0;
      if (i == 2503) rst_n = 1;
      cyc();
    end
    bus_req = 0; tx_ready = 0; rx_valid = 0;
    idle(4);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule